// File: doc/BRIEF.md
# Core-Local Level/Priority Interrupt Controller

This block sits beside a single processor hart and collects a parameterised number of interrupt source lines (87 by default). Each line owns four byte-wide registers: a pending flag, an enable flag, an attribute byte (trigger mode and dispatch style) and a control byte. Sources pass through a two-stage synchroniser. Each line then latches its request as level-sensitive, rising-edge or falling-edge, as its attribute byte selects.

Each control byte is split at run time into a level part (its upper bits) and a priority part (the rest). A software-set level-width field gives the split. Among the lines that are both pending and enabled, the controller picks the one with the highest level, then the highest priority, then the lowest line number. A request goes to the core only when the winner's level is strictly above a software threshold. The core sees the winner's ID, level and vectoring flag, and it clears an edge-triggered line by acknowledging its ID. Software reaches all registers over a simple 32-bit word bus with byte enables. Reads return combinationally while the select is high.

Top module: `lvl_intc`

## Requirements
- R1: After reset, every pending, enable, attribute and control field, the level-width field and the threshold are 0, and `irq_req_o` is 0.
- R2: The global word at 0x0000 holds the configuration byte in bits 7:0. Bits 4:1 are the read/write level-width field, bit 0 reads as 1, and bits 7:5 read as 0.
- R3: The read-only word at 0x0004 reports the number of implemented control bits in bits 24:21, the version in bits 20:13 and the line count in bits 12:0. The threshold is the top byte (bits 31:24) of the word at 0x0008.
- R4: The word of line i is at 0x1000+4*i: pending in bit 0, enable in bit 8, attribute in bits 23:16, control in bits 31:24. Bits 7:1 and 15:9 read as 0 and ignore writes.
- R5: Attribute bit 16 is the vectored flag. Bits 18:17 hold the trigger mode: 00 or 10 is level, 01 is rising edge, 11 is falling edge. Bits 21:19 read 0 and bits 23:22 read as 11.
- R6: On a level-triggered line, pending follows the synchronised input, and software writes to the pending bit have no effect.
- R7: On an edge-triggered line, the selected edge sets pending, and a software write sets or clears it.
- R8: Pulsing `ack_i` with `ack_id_i` clears the pending bit of an edge-triggered line with that ID. On a level-triggered line it has no effect.
- R9: The winner among pending and enabled lines has the highest level, then the highest priority, and on a full tie the lowest line number.
- R10: With level width n (values above 8 are treated as 8), the level is the control byte with its low 8-n bits forced to ones, and the priority is those low 8-n bits.
- R11: `irq_req_o` is 1 only when a winner exists and its level is strictly greater than the threshold.
- R12: One cycle after the arbitration state changes, `irq_id_o`, `irq_lvl_o` and `irq_shv_o` give the winner's line number, level and vectored flag.
- R13: The control byte keeps only its upper CTL_BITS bits. Its unimplemented low bits read as ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Interrupt source lines |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 16 | Byte address of a 32-bit word |
| bus_be_i | input | 4 | Byte enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | IDW | Winning line number |
| irq_lvl_o | output | 8 | Winning level |
| irq_shv_o | output | 1 | Winning line's vectored flag |
| ack_i | input | 1 | Acknowledge pulse |
| ack_id_i | input | IDW | Line number being acknowledged |

## Verification
The assertions take three things for granted. Each source change lasts long enough to pass the synchroniser and produce at most one edge. Acknowledges name a line that exists. Bus addresses are word aligned. The stimulus keeps to this by waiting six cycles after every source change and by drawing acknowledge IDs only from implemented lines. It also writes the attribute byte before the other bytes of a line, so that a pending write always meets the new trigger mode. The random phase reconfigures lines, flips sources, moves the level width and the threshold, and acknowledges lines. A bench model derived from the requirements predicts the winner after every step.

// File: rtl/lvl_intc.sv
module lvl_intc #(
  parameter int N_SRC = 87,
  parameter int CTL_BITS = 4,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int IDW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [15:0]      bus_addr_i,
  input  logic [3:0]       bus_be_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             irq_req_o,
  output logic [IDW-1:0]   irq_id_o,
  output logic [7:0]       irq_lvl_o,
  output logic             irq_shv_o,
  input  logic             ack_i,
  input  logic [IDW-1:0]   ack_id_i
);
  localparam logic [7:0] CTL_PAD = 8'hFF >> CTL_BITS;

  logic [N_SRC-1:0] s1_q, s2_q, prv_q, ip_q, ie_q, shv_q, act;
  logic [1:0]          trig_q [N_SRC];
  logic [CTL_BITS-1:0] ctl_q  [N_SRC];
  logic [3:0] lvlw_q;
  logic [7:0] thr_q;

  logic          win_found, win_shv;
  logic [15:0]   win_key, cand_key;
  logic [IDW-1:0] win_id;

  wire           wr      = bus_sel_i & bus_we_i;
  wire [9:0]     lsel    = bus_addr_i[11:2];
  wire [IDW-1:0] lidx    = lsel[IDW-1:0];
  wire           in_glob = bus_addr_i[15:12] == 4'h0;
  wire           in_line = bus_addr_i[15:12] == 4'h1 && int'(lsel) < N_SRC;
  wire [3:0]     lw_eff  = lvlw_q > 4'd8 ? 4'd8 : lvlw_q;
  wire [7:0]     low_msk = 8'hFF >> lw_eff;

  assign act = ip_q & ie_q;

  function automatic logic [7:0] ctl8(input logic [CTL_BITS-1:0] c);
    return (8'(c) << (8 - CTL_BITS)) | CTL_PAD;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; prv_q <= '0;
    end else begin
      s1_q <= src_i; s2_q <= s1_q; prv_q <= s2_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ip_q <= '0; ie_q <= '0; shv_q <= '0;
      lvlw_q <= '0; thr_q <= '0;
      for (int i = 0; i < N_SRC; i++) begin
        trig_q[i] <= '0;
        ctl_q[i]  <= '0;
      end
    end else begin
      if (wr && in_glob && lsel == 10'd0 && bus_be_i[0]) lvlw_q <= bus_wdata_i[4:1];
      if (wr && in_glob && lsel == 10'd2 && bus_be_i[3]) thr_q  <= bus_wdata_i[31:24];
      for (int i = 0; i < N_SRC; i++) begin
        if (wr && in_line && lsel == 10'(i)) begin
          if (bus_be_i[1]) ie_q[i] <= bus_wdata_i[8];
          if (bus_be_i[2]) begin
            shv_q[i]  <= bus_wdata_i[16];
            trig_q[i] <= bus_wdata_i[18:17];
          end
          if (bus_be_i[3]) ctl_q[i] <= bus_wdata_i[31 -: CTL_BITS];
        end
        if (!trig_q[i][0])
          ip_q[i] <= s2_q[i];
        else if (trig_q[i][1] ? (prv_q[i] & ~s2_q[i]) : (s2_q[i] & ~prv_q[i]))
          ip_q[i] <= 1'b1;
        else if (ack_i && ack_id_i == IDW'(i))
          ip_q[i] <= 1'b0;
        else if (wr && in_line && lsel == 10'(i) && bus_be_i[0])
          ip_q[i] <= bus_wdata_i[0];
      end
    end

  always_comb begin
    win_found = 1'b0;
    win_key   = '0;
    win_id    = '0;
    win_shv   = 1'b0;
    cand_key  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      cand_key = {ctl8(ctl_q[i]) | low_msk, ctl8(ctl_q[i]) & low_msk};
      if (act[i] && (!win_found || cand_key > win_key)) begin
        win_found = 1'b1;
        win_key   = cand_key;
        win_id    = IDW'(i);
        win_shv   = shv_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_req_o <= 1'b0; irq_id_o <= '0; irq_lvl_o <= '0; irq_shv_o <= 1'b0;
    end else begin
      irq_req_o <= win_found && win_key[15:8] > thr_q;
      irq_id_o  <= win_id;
      irq_lvl_o <= win_key[15:8];
      irq_shv_o <= win_shv;
    end

  always_comb begin
    bus_rdata_o = '0;
    if (in_glob) begin
      case (lsel)
        10'd0:   bus_rdata_o = {24'b0, 3'b0, lvlw_q, 1'b1};
        10'd1:   bus_rdata_o = {7'b0, 4'(CTL_BITS), VERSION, 13'(N_SRC)};
        10'd2:   bus_rdata_o = {thr_q, 24'b0};
        default: bus_rdata_o = '0;
      endcase
    end else if (in_line) begin
      bus_rdata_o = {ctl8(ctl_q[lidx]), 2'b11, 3'b000, trig_q[lidx], shv_q[lidx],
                     7'b0, ie_q[lidx], 7'b0, ip_q[lidx]};
    end
  end
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int N_SRC = 87,
  parameter int IDW = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel_i,
  input logic [15:0]      bus_addr_i,
  input logic [31:0]      bus_rdata_o,
  input logic             irq_req_o,
  input logic [IDW-1:0]   irq_id_o,
  input logic [7:0]       irq_lvl_o,
  input logic [N_SRC-1:0] act,
  input logic [7:0]       thr_q
);
  logic [N_SRC-1:0] act_d;
  logic [7:0]       thr_d;

  always_ff @(posedge clk) begin
    act_d <= act;
    thr_d <= thr_q;
  end

  wire line_rd = bus_sel_i && bus_addr_i[15:12] == 4'h1 && int'(bus_addr_i[11:2]) < N_SRC;
  wire cfg_rd  = bus_sel_i && bus_addr_i == 16'h0000;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !irq_req_o); // R1
  AST_CFG_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |-> bus_rdata_o[0] && bus_rdata_o[7:5] == 3'b000); // R2
  AST_LINE_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    line_rd |-> bus_rdata_o[7:1] == 7'd0 && bus_rdata_o[15:9] == 7'd0
                && bus_rdata_o[23:19] == 5'b11000); // R4 R5
  AST_REQ_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> act_d[irq_id_o]); // R9
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    act_d == '0 |-> !irq_req_o); // R9
  AST_REQ_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> irq_lvl_o > thr_d); // R11
endmodule

bind lvl_intc lvl_intc_chk #(.N_SRC(N_SRC), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .irq_req_o(irq_req_o), .irq_id_o(irq_id_o),
  .irq_lvl_o(irq_lvl_o), .act(act), .thr_q(thr_q)
);

// File: tb/lvl_intc_tb.sv
`timescale 1ns/1ps
module lvl_intc_tb;
  localparam int N = 87;
  localparam int IDW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic sel = 0, we = 0, ack = 0;
  logic [15:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0, rdata;
  logic [IDW-1:0] ack_id = '0;
  logic req, shv;
  logic [IDW-1:0] id;
  logic [7:0] lvl;

  int nchk = 0, nfail = 0;

  logic [N-1:0] m_src = '0, m_ip = '0, m_ie = '0, m_shv = '0;
  logic [1:0] m_trig [N];
  logic [3:0] m_ctl [N];
  logic [3:0] m_lw = '0;
  logic [7:0] m_thr = '0;

  always #10 clk = ~clk;

  lvl_intc u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_req_o(req), .irq_id_o(id), .irq_lvl_o(lvl), .irq_shv_o(shv),
    .ack_i(ack), .ack_id_i(ack_id)
  );

  function automatic logic [15:0] la(input int i);
    return 16'(32'h1000 + 4 * i);
  endfunction

  task automatic check(input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, a, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] b);
    @(posedge clk); #1; sel = 1; we = 1; addr = a; wdata = d; be = b;
    @(posedge clk); #1; sel = 0; we = 0; be = '0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(posedge clk); #1; sel = 1; we = 0; addr = a;
    #8; d = rdata;
    @(posedge clk); #1; sel = 0;
  endtask

  task automatic set_line(input int i, input bit en, input logic [1:0] tr, input bit sv,
                          input logic [3:0] c, input bit p);
    bus_wr(la(i), {8'h00, 5'b0, tr, sv, 16'h0}, 4'b0100);
    if (tr[0] && !m_trig[i][0]) m_ip[i] = m_src[i];
    m_trig[i] = tr; m_shv[i] = sv;
    bus_wr(la(i), {c, 4'h0, 8'h00, 7'b0, en, 7'b0, p}, 4'b1011);
    m_ie[i] = en; m_ctl[i] = c;
    if (tr[0]) m_ip[i] = p;
    idle(3);
  endtask

  task automatic drive_src(input logic [N-1:0] nv);
    for (int i = 0; i < N; i++)
      if (nv[i] != m_src[i] && m_trig[i][0] && (m_trig[i][1] ? !nv[i] : nv[i])) m_ip[i] = 1'b1;
    m_src = nv;
    @(posedge clk); #1; src = nv;
    idle(6);
  endtask

  task automatic do_ack(input int i);
    @(posedge clk); #1; ack = 1; ack_id = IDW'(i);
    @(posedge clk); #1; ack = 0;
    if (m_trig[i][0]) m_ip[i] = 1'b0;
    idle(3);
  endtask

  task automatic set_lw(input logic [3:0] v);
    bus_wr(16'h0000, {27'b0, v, 1'b0}, 4'b0001);
    m_lw = v;
    idle(3);
  endtask

  task automatic set_thr(input logic [7:0] v);
    bus_wr(16'h0008, {v, 24'h0}, 4'b1000);
    m_thr = v;
    idle(3);
  endtask

  task automatic model_win(output bit r, output int wi, output logic [7:0] wl, output bit ws);
    logic [3:0] lw;
    logic [7:0] msk, c8;
    logic [15:0] k, bk;
    bit f;
    lw = m_lw > 8 ? 4'd8 : m_lw;
    msk = 8'hFF >> lw;
    f = 0; bk = '0; wi = 0; ws = 0;
    for (int i = 0; i < N; i++) begin
      c8 = {m_ctl[i], 4'hF};
      k = {c8 | msk, c8 & msk};
      if (m_ie[i] && (m_trig[i][0] ? m_ip[i] : m_src[i]) && (!f || k > bk)) begin
        f = 1; bk = k; wi = i; ws = m_shv[i];
      end
    end
    wl = bk[15:8];
    r = f && wl > m_thr;
  endtask

  task automatic check_out(input string tag);
    bit r, ws;
    int wi;
    logic [7:0] wl;
    model_win(r, wi, wl, ws);
    @(negedge clk);
    check({tag, " req"}, 32'(req), 32'(r));
    if (r) begin
      check({tag, " id"}, 32'(id), 32'(wi));
      check({tag, " lvl"}, 32'(lvl), 32'(wl));
      check({tag, " shv"}, 32'(shv), 32'(ws));
    end
  endtask

  task automatic expect_win(input string tag, input bit r, input int wi, input logic [7:0] wl);
    @(negedge clk);
    check({tag, " req"}, 32'(req), 32'(r));
    if (r) begin
      check({tag, " id"}, 32'(id), 32'(wi));
      check({tag, " lvl"}, 32'(lvl), 32'(wl));
    end
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] nv;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin m_trig[i] = '0; m_ctl[i] = '0; end
    idle(3);
    #1 rst_n = 1;
    idle(2);

    @(negedge clk); check("R1 req after reset", 32'(req), 0);
    bus_rd(16'h0000, d); check("R1 R2 config reset", d, 32'h1);
    bus_rd(16'h0004, d); check("R3 info word", d, (32'd4 << 21) | (32'h11 << 13) | 32'd87);
    bus_rd(16'h0008, d); check("R1 R3 threshold reset", d, 0);
    bus_rd(la(0), d); check("R1 R4 R5 R13 line0 reset", d, 32'h0FC0_0000);
    bus_rd(la(N - 1), d); check("R4 R5 last line reset", d, 32'h0FC0_0000);

    bus_wr(16'h0000, 32'hFFFF_FFFF, 4'b0001);
    bus_rd(16'h0000, d); check("R2 level width read/write", d, 32'h1F);
    bus_wr(la(0), 32'hFFFF_FFFF, 4'b0011); m_ie[0] = 1;
    bus_rd(la(0), d); check("R4 R6 upper bits and level pending write", d, 32'h0FC0_0100);
    bus_wr(la(0), 32'h0000_0000, 4'b0010); m_ie[0] = 0;
    set_lw(3);

    set_line(5, 1, 2'b00, 1, 4'b0010, 0);
    drive_src(m_src | (N'(1) << 5));
    expect_win("R6 R12 level line", 1, 5, 8'h3F);
    @(negedge clk); check("R12 vectored flag", 32'(shv), 1);
    bus_wr(la(5), 32'h0, 4'b0001);
    bus_rd(la(5), d); check("R6 R13 level write ignored", d, 32'h2FC1_0101);

    set_line(9, 1, 2'b01, 0, 4'b0100, 0);
    drive_src(m_src | (N'(1) << 9));
    expect_win("R7 R9 rising edge higher level", 1, 9, 8'h5F);
    do_ack(9);
    expect_win("R8 ack clears edge line", 1, 5, 8'h3F);

    set_line(12, 1, 2'b11, 0, 4'b0100, 0);
    drive_src(m_src | (N'(1) << 12));
    expect_win("R7 falling mode ignores rise", 1, 5, 8'h3F);
    drive_src(m_src & ~(N'(1) << 12));
    expect_win("R7 falling edge", 1, 12, 8'h5F);
    set_line(9, 1, 2'b01, 0, 4'b0100, 1);
    expect_win("R9 tie lowest id", 1, 9, 8'h5F);
    set_line(12, 1, 2'b11, 0, 4'b0101, 1);
    expect_win("R9 R10 priority decides", 1, 12, 8'h5F);

    set_thr(8'h5F);
    expect_win("R11 level equal to threshold", 0, 0, 8'h00);
    set_thr(8'h5E);
    expect_win("R11 level above threshold", 1, 12, 8'h5F);
    set_thr(8'h00);

    set_lw(4'd12);
    bus_rd(16'h0000, d); check("R2 level width 12 readback", d, 32'h19);
    expect_win("R10 width clamped to 8", 1, 12, 8'h5F);
    set_lw(4'd0);
    expect_win("R10 width 0 all priority", 1, 12, 8'hFF);
    set_lw(4'd3);

    do_ack(5);
    bus_rd(la(5), d); check("R8 ack on level line no effect", d, 32'h2FC1_0101);
    set_line(12, 1, 2'b11, 0, 4'b0101, 0);
    check_out("R7 software clear");

    for (int it = 0; it < 300; it++) begin
      case ($urandom % 4)
        0: begin
          int ln;
          ln = ($urandom % 5 == 0) ? int'($urandom % N) : int'($urandom % 16);
          set_line(ln, 1'($urandom), 2'($urandom), 1'($urandom), 4'($urandom), 1'($urandom));
        end
        1: begin
          nv = m_src;
          nv[$urandom % 16] ^= 1'b1;
          nv[$urandom % 16] ^= 1'b1;
          drive_src(nv);
        end
        2: if ($urandom % 2) set_lw(4'($urandom));
           else set_thr(($urandom % 3 == 0) ? 8'($urandom) : 8'h00);
        default: do_ack(int'($urandom % 16));
      endcase
      check_out("R9 R10 R11 R12 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule